// File: doc/BRIEF.md
# Two-Way Page Translation Cache with Reference and Modify Flags

This block caches recent virtual-to-physical page translations. A requester presents a virtual address together with a read/write flag. One cycle later the block reports whether the page was found. On a hit it returns the physical address, which is the cached physical page number joined to the unchanged low offset bits. It also returns the entry's reference and modify flags as they stood before this access, and then sets those flags according to the kind of access.

When a lookup misses, a miss handler outside the block reads the page table. It writes the translation in through the refill port and then retries the access. A flush input clears every translation at once, for use when the running address space changes. The storage holds a number of sets of two ways each. The set is chosen by the low bits of the virtual page number. A refill takes an empty way if the set has one. Otherwise it takes the way that was used least recently.

Top module: `pgx_tlb`

## Requirements
- R1: On a hit, `rsp_paddr` equals the cached physical page number in bits [19:8] followed by the request's offset `req_vaddr[7:0]` in bits [7:0].
- R2: The set index is `req_vaddr[11:8]` (the low 4 bits of the page number) and the tag is `req_vaddr[31:12]`. A lookup hits only when an entry of that set is valid and has an equal tag. A different tag in the same set misses.
- R3: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. On a miss, `rsp_hit` is 0 and `rsp_paddr` is 0.
- R4: Every hit, whether a read or a write, sets the entry's reference flag. `rsp_used` reports the flag's value before the access.
- R5: A write hit sets the entry's modify flag and a read hit leaves it unchanged. `rsp_dirty` reports the flag's value before the access.
- R6: A refill installs a valid entry with both flags clear. It goes into an invalid way of the set if there is one. Otherwise it goes into the least recently used way, where both hits and refills count as uses.
- R7: A flush makes every entry invalid from the next clock edge on. A refill in the same cycle as a flush is discarded.
- R8: A lookup in the same cycle as a refill or a flush is answered from the contents held before that clock edge.
- R9: After reset, every entry is invalid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address: page number [31:8], offset [7:0] |
| req_write | input | 1 | 1 = write access, 0 = read access |
| fill_valid | input | 1 | Refill request this cycle |
| fill_vpn | input | 24 | Virtual page number to install |
| fill_ppn | input | 12 | Physical page number to install |
| flush | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found a valid translation |
| rsp_paddr | output | 20 | Physical address on a hit, 0 on a miss |
| rsp_used | output | 1 | Reference flag before the access |
| rsp_dirty | output | 1 | Modify flag before the access |

## Verification
A lookup can share a cycle with a flush or with a refill, and the order between them decides what the requester sees. The bench raises a flush in the same cycle as a hitting lookup. It expects that lookup to be reported as a hit and the next lookup of the same page to miss. It also raises a refill of a page in the same cycle as a lookup of that page, and expects a miss at once and a hit on the retry. A third case raises flush and refill together and expects that the refill leaves no trace.

// File: rtl/pgx_tlb_pkg.sv
package pgx_tlb_pkg;
    localparam int unsigned DEF_OFF_W = 8;
    localparam int unsigned DEF_VPN_W = 24;
    localparam int unsigned DEF_PPN_W = 12;
    localparam int unsigned DEF_SETS  = 16;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/pgx_tlb_match.sv
module pgx_tlb_match #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TAG_W = 20
) (
    input  logic [WAYS-1:0]       way_valid,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]      look_tag,
    output logic [WAYS-1:0]       hit_vec,
    output logic                  any_hit
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == look_tag);
    end
    assign any_hit = |hit_vec;
endmodule

// File: rtl/pgx_tlb_victim.sv
module pgx_tlb_victim (
    input  logic [1:0] set_valid,
    input  logic       lru_way,
    output logic       pick_way
);
    always_comb begin
        if (!set_valid[0])      pick_way = 1'b0;
        else if (!set_valid[1]) pick_way = 1'b1;
        else                    pick_way = lru_way;
    end
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
    parameter int unsigned OFF_W = pgx_tlb_pkg::DEF_OFF_W,
    parameter int unsigned VPN_W = pgx_tlb_pkg::DEF_VPN_W,
    parameter int unsigned PPN_W = pgx_tlb_pkg::DEF_PPN_W,
    parameter int unsigned SETS  = pgx_tlb_pkg::DEF_SETS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    input  logic                   req_write,
    input  logic                   fill_valid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic                   flush,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [PPN_W+OFF_W-1:0] rsp_paddr,
    output logic                   rsp_used,
    output logic                   rsp_dirty
);
    import pgx_tlb_pkg::*;

    localparam int unsigned WAYS  = 2;
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = VPN_W - IDX_W;
    localparam int unsigned VA_W  = VPN_W + OFF_W;
    localparam int unsigned PA_W  = PPN_W + OFF_W;

    typedef struct packed {
        logic             vld;
        logic             used;
        logic             dirty;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } entry_t;

    typedef struct packed {
        entry_t [SETS-1:0][WAYS-1:0] ent;
        logic   [SETS-1:0]           lru;
        logic                        rv;
        logic                        rh;
        logic   [PA_W-1:0]           pa;
        logic                        ru;
        logic                        rd;
    } state_t;

    state_t s_d, s_q;

    logic [VPN_W-1:0]      req_vpn;
    logic [IDX_W-1:0]      req_idx;
    logic [TAG_W-1:0]      req_tag;
    logic [OFF_W-1:0]      req_off;
    acc_kind_e             req_kind;
    logic [IDX_W-1:0]      fill_idx;
    logic [TAG_W-1:0]      fill_tag;
    logic [WAYS-1:0]       look_valid;
    logic [WAYS*TAG_W-1:0] look_tags;
    logic [WAYS-1:0]       hit_vec;
    logic                  any_hit;
    logic                  hit_way;
    logic [WAYS-1:0]       fill_set_valid;
    logic                  fill_way;
    entry_t                hit_ent;

    assign req_vpn  = req_vaddr[VA_W-1:OFF_W];
    assign req_idx  = req_vpn[IDX_W-1:0];
    assign req_tag  = req_vpn[VPN_W-1:IDX_W];
    assign req_off  = req_vaddr[OFF_W-1:0];
    assign req_kind = acc_kind_e'(req_write);
    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_sel
        assign look_valid[w]               = s_q.ent[req_idx][w].vld;
        assign look_tags[w*TAG_W +: TAG_W] = s_q.ent[req_idx][w].tag;
        assign fill_set_valid[w]           = s_q.ent[fill_idx][w].vld;
    end

    pgx_tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
        .way_valid (look_valid),
        .way_tags  (look_tags),
        .look_tag  (req_tag),
        .hit_vec   (hit_vec),
        .any_hit   (any_hit)
    );

    pgx_tlb_victim i_victim (
        .set_valid (fill_set_valid),
        .lru_way   (s_q.lru[fill_idx]),
        .pick_way  (fill_way)
    );

    assign hit_way = hit_vec[1];
    assign hit_ent = s_q.ent[req_idx][hit_way];

    always_comb begin
        s_d    = s_q;
        s_d.rv = req_valid;
        s_d.rh = 1'b0;
        s_d.pa = '0;
        s_d.ru = 1'b0;
        s_d.rd = 1'b0;

        if (req_valid && any_hit) begin
            s_d.rh = 1'b1;
            s_d.pa = {hit_ent.ppn, req_off};
            s_d.ru = hit_ent.used;
            s_d.rd = hit_ent.dirty;
            s_d.ent[req_idx][hit_way].used = 1'b1;
            if (req_kind == ACC_WRITE) begin
                s_d.ent[req_idx][hit_way].dirty = 1'b1;
            end
            s_d.lru[req_idx] = ~hit_way;
        end

        if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    s_d.ent[s][w].vld = 1'b0;
                end
            end
        end else if (fill_valid) begin
            s_d.ent[fill_idx][fill_way] = '{vld: 1'b1, used: 1'b0, dirty: 1'b0,
                                            tag: fill_tag, ppn: fill_ppn};
            s_d.lru[fill_idx] = ~fill_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rv;
    assign rsp_hit   = s_q.rh;
    assign rsp_paddr = s_q.pa;
    assign rsp_used  = s_q.ru;
    assign rsp_dirty = s_q.rd;
endmodule

// File: rtl/pgx_tlb_chk.sv
module pgx_tlb_chk #(
    parameter int unsigned OFF_W = 8,
    parameter int unsigned VPN_W = 24,
    parameter int unsigned PPN_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [VPN_W+OFF_W-1:0] req_vaddr,
    input logic                   req_write,
    input logic                   fill_valid,
    input logic                   flush,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic [PPN_W+OFF_W-1:0] rsp_paddr,
    input logic                   rsp_used,
    input logic                   rsp_dirty
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R3
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R3
    AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0)); // R3
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !flush) |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R1
    AST_FLUSH_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush ##1 req_valid) |=> !rsp_hit); // R7
    AST_REPEAT_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && rsp_hit && !flush && !fill_valid
         && !$past(flush) && !$past(fill_valid) && req_vaddr == $past(req_vaddr))
        |=> (rsp_hit && rsp_used)); // R4
    AST_REPEAT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rsp_valid && rsp_hit && $past(req_write) && !flush && !fill_valid
         && !$past(flush) && !$past(fill_valid) && req_vaddr == $past(req_vaddr))
        |=> (rsp_hit && rsp_dirty)); // R5
endmodule

bind pgx_tlb pgx_tlb_chk #(.OFF_W(OFF_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .fill_valid(fill_valid), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_used(rsp_used), .rsp_dirty(rsp_dirty)
);

// File: tb/test_pgx_tlb.sv
module test_pgx_tlb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_write;
    logic        fill_valid;
    logic [23:0] fill_vpn;
    logic [11:0] fill_ppn;
    logic        flush;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [19:0] rsp_paddr;
    logic        rsp_used;
    logic        rsp_dirty;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pgx_tlb i_pgx_tlb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .rsp_used(rsp_used), .rsp_dirty(rsp_dirty)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; flush = 1'b0;
    endtask

    // drive a lookup (optionally with flush/fill in the same cycle), sample after the edge
    task automatic look(input logic [31:0] va, input logic wr, input logic with_flush,
                        input logic with_fill, input logic [23:0] fv, input logic [11:0] fp);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        flush = with_flush; fill_valid = with_fill; fill_vpn = fv; fill_ppn = fp;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic expect_rsp(input string req, input logic hit, input logic [19:0] pa,
                              input logic used, input logic dirty);
        check({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
        check({req, " hit"},   {31'b0, rsp_hit},   {31'b0, hit});
        check({req, " paddr"}, {12'b0, rsp_paddr}, {12'b0, pa});
        if (hit) begin
            check({req, " used"},  {31'b0, rsp_used},  {31'b0, used});
            check({req, " dirty"}, {31'b0, rsp_dirty}, {31'b0, dirty});
        end
    endtask

    task automatic fill(input logic [23:0] fv, input logic [11:0] fp, input logic with_flush);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = fv; fill_ppn = fp; flush = with_flush;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        check("R9 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        look(32'h0000_1370, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R9 empty after reset", 1'b0, 20'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 no response without request", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_fill_hit();
        fill(24'h000013, 12'h2A5, 1'b0);
        look(32'h0000_1370, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R1 R6 first hit flags clear", 1'b1, 20'h2A570, 1'b0, 1'b0);
        look(32'h0000_13FF, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R4 used set by read", 1'b1, 20'h2A5FF, 1'b1, 1'b0);
        look(32'h1000_1370, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R2 tag mismatch same set", 1'b0, 20'h0, 1'b0, 1'b0);
    endtask

    task automatic t_dirty();
        look(32'h0000_1301, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R5 read leaves dirty clear", 1'b1, 20'h2A501, 1'b1, 1'b0);
        look(32'h0000_1302, 1'b1, 1'b0, 1'b0, '0, '0);
        expect_rsp("R5 write reports prior dirty", 1'b1, 20'h2A502, 1'b1, 1'b0);
        look(32'h0000_1303, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R5 dirty after write", 1'b1, 20'h2A503, 1'b1, 1'b1);
    endtask

    task automatic t_victim();
        fill(24'h000023, 12'h111, 1'b0);             // empty way taken
        look(32'h0000_2344, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R6 second fill keeps first", 1'b1, 20'h11144, 1'b0, 1'b0);
        look(32'h0000_1310, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R6 first still present", 1'b1, 20'h2A510, 1'b1, 1'b1);
        fill(24'h000033, 12'h0C3, 1'b0);             // evicts least recent (0x23)
        look(32'h0000_2344, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R6 lru way evicted", 1'b0, 20'h0, 1'b0, 1'b0);
        look(32'h0000_1320, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R6 recent way kept", 1'b1, 20'h2A520, 1'b1, 1'b1);
        look(32'h0000_3399, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R6 new entry hit", 1'b1, 20'h0C399, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle();
        look(32'h0000_1330, 1'b0, 1'b1, 1'b0, '0, '0);
        expect_rsp("R8 lookup with flush sees old", 1'b1, 20'h2A530, 1'b1, 1'b1);
        look(32'h0000_1330, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R7 miss after flush", 1'b0, 20'h0, 1'b0, 1'b0);
        look(32'h0000_3330, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R7 other entry flushed", 1'b0, 20'h0, 1'b0, 1'b0);
        fill(24'h000013, 12'h2A5, 1'b1);
        look(32'h0000_1330, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R7 fill dropped under flush", 1'b0, 20'h0, 1'b0, 1'b0);
        look(32'h0000_5507, 1'b0, 1'b0, 1'b1, 24'h000055, 12'hABC);
        expect_rsp("R8 lookup with fill sees old", 1'b0, 20'h0, 1'b0, 1'b0);
        look(32'h0000_5507, 1'b0, 1'b0, 1'b0, '0, '0);
        expect_rsp("R8 retry hits", 1'b1, 20'hABC07, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_dirty();
        t_victim();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule